// File: doc/BRIEF.md
# D-PHY Receiver Bring-Up Sequencer

This block takes a MIPI D-PHY receiver from its held-in-reset condition to normal operation, and back to shutdown on request. A single start pulse captures a lane-enable mask and a precomputed high-speed frequency-range code. The block then walks the power-up steps in a fixed order. It holds the PHY in reset and shutdown and raises the test-clear line. It puts every lane into receive mode with turnaround disabled and no turn request. After timed waits it releases the test clear. It programs the PHY's clock lane and frequency range through its test port, turns on the clock lane, and finally lifts shutdown and then reset, each after a timed gap.

The test port is driven by a small access engine inside the block. The sequencer hands it one access at a time through a request/done handshake. The engine presents the test code on a falling test-clock edge with test-enable high, and data on a rising edge with test-enable low. Every wait is counted in system clocks, and its minimum is set by a parameter. The block also reports the number of active lanes to the CSI-2 host, as the index of the highest lane enabled. It raises a ready flag when the PHY is released from reset.

Top module: `dphy_rx_bringup`

## Requirements
- R1: After reset, RSTZ, SHUTDOWNZ, TESTCLR, ENABLECLK, ready and busy are 0, the turnaround-disable, turn-request and force-receive buses are all 0, TESTCLK is 1 and TESTEN is 0.
- R2: A start pulse is accepted in the idle or ready state. RSTZ goes low first, then in a later cycle SHUTDOWNZ and ENABLECLK go low, then in a later cycle TESTCLR goes high.
- R3: When TESTCLR falls, every turn-request bit is 0, every turnaround-disable bit is 1 and every force-receive bit is 1.
- R4: TESTCLR stays high for at least WAIT_CLR_CYC clocks, and at least WAIT_CLR_CYC clocks pass from its fall to the first rise of TESTEN.
- R5: The test port carries exactly three accesses, in this order: a write of 0x15 to code 0x34, a write of the zero-extended range code to code 0x44, and an address-only access to code 0x00. A code is taken on a falling TESTCLK edge with TESTEN=1, and data on a rising TESTCLK edge with TESTEN=0.
- R6: Once the accesses are done, TESTCLK rests at 1 and TESTEN at 0.
- R7: active_lanes_o, captured at start, equals the bit position of the highest set bit of the lane mask (0x1 gives 0, 0x3 gives 1, 0xF gives 3), and is 0 for an empty mask.
- R8: ENABLECLK rises after the last access ends. SHUTDOWNZ rises at least WAIT_EN_CYC clocks later, and RSTZ rises at least WAIT_EN_CYC clocks after that.
- R9: ready_o rises in the same cycle as RSTZ and implies RSTZ and SHUTDOWNZ are high. busy_o is high from an accepted start until then.
- R10: A start pulse that arrives while the sequence runs is ignored: the captured lane count and range code are unchanged.
- R11: A standby pulse in the ready state drops SHUTDOWNZ, then RSTZ and ENABLECLK in the next cycle, and leaves the block idle. A standby pulse in the idle state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start bring-up (one-cycle pulse) |
| standby_i | input | 1 | Return PHY to shutdown (one-cycle pulse) |
| lane_mask_i | input | NUM_LANES | Lane-enable mask, captured at start |
| hsfreq_i | input | FREQ_W | High-speed frequency-range code, captured at start |
| phy_rstz_o | output | 1 | PHY reset, active low |
| phy_shutdownz_o | output | 1 | PHY shutdown, active low |
| phy_testclr_o | output | 1 | PHY test-interface clear |
| phy_testclk_o | output | 1 | PHY test-interface clock |
| phy_testen_o | output | 1 | PHY test-interface enable (high selects code phase) |
| phy_testdin_o | output | 8 | PHY test-interface code/data |
| phy_enableclk_o | output | 1 | Clock-lane enable |
| phy_turndisable_o | output | NUM_LANES | Per-lane turnaround disable |
| phy_turnrequest_o | output | NUM_LANES | Per-lane turnaround request |
| phy_forcerx_o | output | NUM_LANES | Per-lane force receive mode |
| active_lanes_o | output | LANE_IDX_W | Highest enabled lane index, for the CSI-2 host |
| ready_o | output | 1 | PHY released and operating |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench decodes the test port the way a PHY would. A sequencer that wrote the range code into the clock-lane slot, skipped the address-only finish, or let TESTEN change on the falling edge would therefore show a wrong address or write log. It measures the gaps between control-line edges. A design that shortened a wait or released RSTZ before SHUTDOWNZ fails the gap checks. A second start is injected mid-sequence with a different mask and range code; a block that re-captured its inputs would report a wrong lane count or write the wrong range. Standby is exercised from ready and from idle. An empty mask and masks with holes test the lane-count rule at its edges.

// File: rtl/dphy_bringup_pkg.sv
package dphy_bringup_pkg;

    localparam logic [7:0] TC_CLK_LANE     = 8'h34;
    localparam logic [7:0] TC_CLK_LANE_VAL = 8'h15;
    localparam logic [7:0] TC_HSFREQ       = 8'h44;
    localparam logic [7:0] TC_NORMAL       = 8'h00;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_SHUT_LO,
        SQ_CLR_HI,
        SQ_LANE_CFG,
        SQ_CLR_WAIT,
        SQ_POST_WAIT,
        SQ_WR_CLK,
        SQ_WR_FREQ,
        SQ_WR_END,
        SQ_EN_WAIT,
        SQ_SHUT_WAIT,
        SQ_READY,
        SQ_SB_RST
    } seq_state_e;

    typedef enum logic [2:0] {
        TP_IDLE,
        TP_ADDR,
        TP_ADDR_FALL,
        TP_DATA,
        TP_DATA_RISE,
        TP_PARK,
        TP_DONE
    } tp_state_e;

    typedef struct packed {
        logic [7:0] code;
        logic [7:0] data;
        logic       addr_only;
    } tp_req_t;

    typedef struct packed {
        logic       clk;
        logic       en;
        logic [7:0] din;
    } tp_pins_t;

    function automatic tp_state_e tp_next(input tp_state_e cur, input logic addr_only);
        unique case (cur)
            TP_ADDR:      return TP_ADDR_FALL;
            TP_ADDR_FALL: return addr_only ? TP_PARK : TP_DATA;
            TP_DATA:      return TP_DATA_RISE;
            default:      return TP_DONE;
        endcase
    endfunction

endpackage

// File: rtl/dphy_wait_timer.sv
module dphy_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load_i)      cnt_q <= value_i;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R4 / R8: a wait must never be loaded with zero length
    assert_wait_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (value_i != '0));

    // R4: the timer only leaves its expired state through a load
    assert_wait_started_by_load_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(expired_o) |-> $past(load_i));
endmodule

// File: rtl/dphy_testport_engine.sv
module dphy_testport_engine
    import dphy_bringup_pkg::*;
#(
    parameter int PHASE_CYC = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  tp_req_t    req_data_i,
    output logic       done_o,
    output logic       testclk_o,
    output logic       testen_o,
    output logic [7:0] testdin_o
);
    localparam int PH_W = $clog2(PHASE_CYC + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASE_CYC - 1);

    tp_state_e       st_q;
    logic [PH_W-1:0] ph_q;
    tp_req_t         cur_q;
    tp_pins_t        pins;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TP_IDLE;
            ph_q  <= '0;
            cur_q <= '0;
        end else begin
            unique case (st_q)
                TP_IDLE: begin
                    if (req_i) begin
                        cur_q <= req_data_i;
                        ph_q  <= PH_LAST;
                        st_q  <= TP_ADDR;
                    end
                end
                TP_DONE: st_q <= TP_IDLE;
                default: begin
                    if (ph_q != '0) begin
                        ph_q <= ph_q - 1'b1;
                    end else begin
                        ph_q <= PH_LAST;
                        st_q <= tp_next(st_q, cur_q.addr_only);
                    end
                end
            endcase
        end
    end

    always_comb begin
        pins = '{clk: 1'b1, en: 1'b0, din: 8'h00};
        unique case (st_q)
            TP_ADDR:      pins = '{clk: 1'b1, en: 1'b1, din: cur_q.code};
            TP_ADDR_FALL: pins = '{clk: 1'b0, en: 1'b1, din: cur_q.code};
            TP_DATA:      pins = '{clk: 1'b0, en: 1'b0, din: cur_q.data};
            TP_DATA_RISE: pins = '{clk: 1'b1, en: 1'b0, din: cur_q.data};
            TP_PARK:      pins = '{clk: 1'b1, en: 1'b1, din: cur_q.code};
            default:      pins = '{clk: 1'b1, en: 1'b0, din: 8'h00};
        endcase
    end

    assign testclk_o = pins.clk;
    assign testen_o  = pins.en;
    assign testdin_o = pins.din;
    assign done_o    = (st_q == TP_DONE);

    // R5: the sequencer only requests an access while the engine is free
    assert_req_only_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
        req_i |-> (st_q == TP_IDLE));

    // R5: every falling test-clock edge carries a code with enable steady high
    assert_code_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(testclk_o) |-> (testen_o && $past(testen_o)));

    // R5: completion is a single-cycle pulse
    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/dphy_lane_counter.sv
module dphy_lane_counter #(
    parameter int NUM_LANES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [NUM_LANES-1:0] mask_i,
    output logic [IDX_W-1:0]     top_idx_o
);
    always_comb begin
        top_idx_o = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (mask_i[i]) top_idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/dphy_rx_bringup.sv
module dphy_rx_bringup
    import dphy_bringup_pkg::*;
#(
    parameter int NUM_LANES    = 4,
    parameter int FREQ_W       = 7,
    parameter int WAIT_CLR_CYC = 4,
    parameter int WAIT_EN_CYC  = 2,
    parameter int PHASE_CYC    = 2,
    localparam int LANE_IDX_W  = (NUM_LANES > 1) ? $clog2(NUM_LANES) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  standby_i,
    input  logic [NUM_LANES-1:0]  lane_mask_i,
    input  logic [FREQ_W-1:0]     hsfreq_i,
    output logic                  phy_rstz_o,
    output logic                  phy_shutdownz_o,
    output logic                  phy_testclr_o,
    output logic                  phy_testclk_o,
    output logic                  phy_testen_o,
    output logic [7:0]            phy_testdin_o,
    output logic                  phy_enableclk_o,
    output logic [NUM_LANES-1:0]  phy_turndisable_o,
    output logic [NUM_LANES-1:0]  phy_turnrequest_o,
    output logic [NUM_LANES-1:0]  phy_forcerx_o,
    output logic [LANE_IDX_W-1:0] active_lanes_o,
    output logic                  ready_o,
    output logic                  busy_o
);
    localparam int TMR_MAX = (WAIT_CLR_CYC > WAIT_EN_CYC) ? WAIT_CLR_CYC : WAIT_EN_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [NUM_LANES-1:0] ALL_LANES = '1;

    seq_state_e            st_q;
    logic                  rstz_q, sd_q, clr_q, enclk_q, ready_q, busy_q;
    logic [NUM_LANES-1:0]  tdis_q, treq_q, frx_q;
    logic [LANE_IDX_W-1:0] lanes_q, lane_idx;
    logic [FREQ_W-1:0]     freq_q;
    logic                  req_v_q;
    tp_req_t               req_q;
    logic                  tp_done;
    logic                  tmr_load, tmr_exp;
    logic [TMR_W-1:0]      tmr_val;

    dphy_lane_counter #(.NUM_LANES(NUM_LANES), .IDX_W(LANE_IDX_W)) u_lanes (
        .mask_i    (lane_mask_i),
        .top_idx_o (lane_idx)
    );

    dphy_wait_timer #(.W(TMR_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .load_i    (tmr_load),
        .value_i   (tmr_val),
        .expired_o (tmr_exp)
    );

    dphy_testport_engine #(.PHASE_CYC(PHASE_CYC)) u_tport (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_v_q),
        .req_data_i (req_q),
        .done_o     (tp_done),
        .testclk_o  (phy_testclk_o),
        .testen_o   (phy_testen_o),
        .testdin_o  (phy_testdin_o)
    );

    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = TMR_W'(WAIT_CLR_CYC);
        unique case (st_q)
            SQ_LANE_CFG: tmr_load = 1'b1;
            SQ_CLR_WAIT: tmr_load = tmr_exp;
            SQ_WR_END: begin
                tmr_load = tp_done;
                tmr_val  = TMR_W'(WAIT_EN_CYC);
            end
            SQ_EN_WAIT: begin
                tmr_load = tmr_exp;
                tmr_val  = TMR_W'(WAIT_EN_CYC);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            rstz_q  <= 1'b0;
            sd_q    <= 1'b0;
            clr_q   <= 1'b0;
            enclk_q <= 1'b0;
            ready_q <= 1'b0;
            busy_q  <= 1'b0;
            tdis_q  <= '0;
            treq_q  <= '0;
            frx_q   <= '0;
            lanes_q <= '0;
            freq_q  <= '0;
            req_v_q <= 1'b0;
            req_q   <= '0;
        end else begin
            req_v_q <= 1'b0;
            unique case (st_q)
                SQ_IDLE, SQ_READY: begin
                    if (st_q == SQ_READY && standby_i) begin
                        sd_q    <= 1'b0;
                        ready_q <= 1'b0;
                        busy_q  <= 1'b1;
                        st_q    <= SQ_SB_RST;
                    end else if (start_i) begin
                        rstz_q  <= 1'b0;
                        ready_q <= 1'b0;
                        busy_q  <= 1'b1;
                        lanes_q <= lane_idx;
                        freq_q  <= hsfreq_i;
                        st_q    <= SQ_SHUT_LO;
                    end
                end
                SQ_SHUT_LO: begin
                    sd_q    <= 1'b0;
                    enclk_q <= 1'b0;
                    st_q    <= SQ_CLR_HI;
                end
                SQ_CLR_HI: begin
                    clr_q <= 1'b1;
                    st_q  <= SQ_LANE_CFG;
                end
                SQ_LANE_CFG: begin
                    treq_q <= '0;
                    tdis_q <= ALL_LANES;
                    frx_q  <= ALL_LANES;
                    st_q   <= SQ_CLR_WAIT;
                end
                SQ_CLR_WAIT: begin
                    if (tmr_exp) begin
                        clr_q <= 1'b0;
                        st_q  <= SQ_POST_WAIT;
                    end
                end
                SQ_POST_WAIT: begin
                    if (tmr_exp) begin
                        req_v_q <= 1'b1;
                        req_q   <= '{code: TC_CLK_LANE, data: TC_CLK_LANE_VAL, addr_only: 1'b0};
                        st_q    <= SQ_WR_CLK;
                    end
                end
                SQ_WR_CLK: begin
                    if (tp_done) begin
                        req_v_q <= 1'b1;
                        req_q   <= '{code: TC_HSFREQ, data: 8'(freq_q), addr_only: 1'b0};
                        st_q    <= SQ_WR_FREQ;
                    end
                end
                SQ_WR_FREQ: begin
                    if (tp_done) begin
                        req_v_q <= 1'b1;
                        req_q   <= '{code: TC_NORMAL, data: 8'h00, addr_only: 1'b1};
                        st_q    <= SQ_WR_END;
                    end
                end
                SQ_WR_END: begin
                    if (tp_done) begin
                        enclk_q <= 1'b1;
                        st_q    <= SQ_EN_WAIT;
                    end
                end
                SQ_EN_WAIT: begin
                    if (tmr_exp) begin
                        sd_q <= 1'b1;
                        st_q <= SQ_SHUT_WAIT;
                    end
                end
                SQ_SHUT_WAIT: begin
                    if (tmr_exp) begin
                        rstz_q  <= 1'b1;
                        ready_q <= 1'b1;
                        busy_q  <= 1'b0;
                        st_q    <= SQ_READY;
                    end
                end
                SQ_SB_RST: begin
                    rstz_q  <= 1'b0;
                    enclk_q <= 1'b0;
                    busy_q  <= 1'b0;
                    st_q    <= SQ_IDLE;
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end

    assign phy_rstz_o        = rstz_q;
    assign phy_shutdownz_o   = sd_q;
    assign phy_testclr_o     = clr_q;
    assign phy_enableclk_o   = enclk_q;
    assign phy_turndisable_o = tdis_q;
    assign phy_turnrequest_o = treq_q;
    assign phy_forcerx_o     = frx_q;
    assign active_lanes_o    = lanes_q;
    assign ready_o           = ready_q;
    assign busy_o            = busy_q;

    // R2: test clear is raised only with the PHY held in reset and shutdown
    assert_clr_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_q) |-> (!rstz_q && !sd_q));

    // R3: lane configuration is in place when test clear is released
    assert_lane_cfg_at_release_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(clr_q) |-> (tdis_q == ALL_LANES && frx_q == ALL_LANES && treq_q == '0));

    // R5: no test access while test clear is held
    assert_no_access_in_clear_R5: assert property (@(posedge clk) disable iff (rst)
        req_v_q |-> !clr_q);

    // R8: shutdown is lifted only with the clock lane enabled
    assert_shutdown_after_enclk_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(sd_q) |-> enclk_q);

    // R8: reset is lifted only after shutdown was already lifted
    assert_rstz_after_shutdown_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(rstz_q) |-> (sd_q && $past(sd_q)));

    // R9: ready implies the PHY is fully released
    assert_ready_released_R9: assert property (@(posedge clk) disable iff (rst)
        ready_q |-> (rstz_q && sd_q));

    // R10: captured lane count cannot move while a sequence runs
    assert_lanes_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(lanes_q));

    // R11: a shutdown drop from the running state is followed by a reset drop
    assert_standby_order_R11: assert property (@(posedge clk) disable iff (rst)
        ($fell(sd_q) && rstz_q) |=> $fell(rstz_q));
endmodule

// File: tb/dphy_rx_bringup_tb_top.sv
module dphy_rx_bringup_tb_top;
    localparam int WCLR = 4;
    localparam int WEN  = 2;

    // entry: {mask[12:9], range code[8:2], expected lane index[1:0]}
    localparam logic [12:0] VECS [6] = '{
        {4'h1, 7'h00, 2'd0},
        {4'h3, 7'h2a, 2'd1},
        {4'hf, 7'h7f, 2'd3},
        {4'h4, 7'h15, 2'd2},
        {4'h5, 7'h40, 2'd2},
        {4'ha, 7'h31, 2'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic       start = 1'b0, standby = 1'b0;
    logic [3:0] mask = 4'h0;
    logic [6:0] freq = 7'h00;

    logic       rstz, sd, clr, tclk, ten, enclk, ready, busy;
    logic [7:0] din;
    logic [3:0] tdis, treq, frx;
    logic [1:0] lanes;

    dphy_rx_bringup #(.WAIT_CLR_CYC(WCLR), .WAIT_EN_CYC(WEN)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .standby_i(standby),
        .lane_mask_i(mask), .hsfreq_i(freq),
        .phy_rstz_o(rstz), .phy_shutdownz_o(sd), .phy_testclr_o(clr),
        .phy_testclk_o(tclk), .phy_testen_o(ten), .phy_testdin_o(din),
        .phy_enableclk_o(enclk), .phy_turndisable_o(tdis),
        .phy_turnrequest_o(treq), .phy_forcerx_o(frx),
        .active_lanes_o(lanes), .ready_o(ready), .busy_o(busy)
    );

    int checks = 0, errors = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: edge timestamps and a PHY-side decode of the test port
    logic clr_log = 1'b0;
    int t_rstz_fall, t_sd_fall, t_clr_rise, t_clr_fall, t_en_first, t_en_last_fall;
    int t_enclk_rise, t_sd_rise, t_rstz_rise, t_ready_rise;
    logic cfg_ok;
    logic [7:0] alog [8];
    logic [7:0] wa [8];
    logic [7:0] wd [8];
    logic [7:0] last_addr;
    int n_a, n_w;
    logic p_rstz = 0, p_sd = 0, p_clr = 0, p_tclk = 1, p_ten = 0, p_enclk = 0, p_ready = 0;

    always @(negedge clk) begin
        if (clr_log) begin
            t_rstz_fall = -1; t_sd_fall = -1; t_clr_rise = -1; t_clr_fall = -1;
            t_en_first = -1; t_en_last_fall = -1; t_enclk_rise = -1; t_sd_rise = -1;
            t_rstz_rise = -1; t_ready_rise = -1; cfg_ok = 1'b0; n_a = 0; n_w = 0;
            last_addr = 8'hxx;
        end else begin
            if (p_rstz && !rstz) t_rstz_fall = cyc;
            if (!p_rstz && rstz) t_rstz_rise = cyc;
            if (p_sd && !sd) t_sd_fall = cyc;
            if (!p_sd && sd) t_sd_rise = cyc;
            if (!p_clr && clr) t_clr_rise = cyc;
            if (p_clr && !clr) begin
                t_clr_fall = cyc;
                cfg_ok = (tdis == 4'hf) && (frx == 4'hf) && (treq == 4'h0);
            end
            if (!p_ten && ten && t_clr_fall >= 0 && t_en_first < 0) t_en_first = cyc;
            if (p_ten && !ten) t_en_last_fall = cyc;
            if (!p_enclk && enclk) t_enclk_rise = cyc;
            if (!p_ready && ready) t_ready_rise = cyc;
            if (p_tclk && !tclk && ten) begin
                last_addr = din;
                if (n_a < 8) alog[n_a] = din;
                n_a++;
            end
            if (!p_tclk && tclk && !ten) begin
                if (n_w < 8) begin wa[n_w] = last_addr; wd[n_w] = din; end
                n_w++;
            end
        end
        p_rstz = rstz; p_sd = sd; p_clr = clr; p_tclk = tclk;
        p_ten = ten; p_enclk = enclk; p_ready = ready;
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string rq, input string what, input int act, input int lo);
        checks++;
        if (act < lo) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected at least %0d", rq, what, act, lo);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic bringup(input logic [3:0] m, input logic [6:0] f, input int exp_lanes,
                           input bit from_ready, input bit inject);
        int n;
        mask = m; freq = f; start = 1'b1; clr_log = 1'b1;
        tick();
        start = 1'b0; clr_log = 1'b0;
        n = 0;
        while (!ready && n < 3000) begin
            if (inject && n == 6) begin
                start = 1'b1; mask = 4'h0; freq = 7'h55;
            end else begin
                start = 1'b0;
            end
            tick();
            n++;
        end
        start = 1'b0;
        chk("R9", "ready reached", int'(ready), 1);
        tick();
        chk("R7", "active lane index", int'(lanes), exp_lanes);
        if (inject) chk("R10", "lane index after ignored start", int'(lanes), exp_lanes);
        chk("R5", "code accesses", n_a, 3);
        if (n_a == 3) begin
            chk("R5", "first code", int'(alog[0]), 8'h34);
            chk("R5", "second code", int'(alog[1]), 8'h44);
            chk("R5", "address-only code", int'(alog[2]), 8'h00);
        end
        chk("R5", "data writes", n_w, 2);
        if (n_w == 2) begin
            chk("R5", "clock lane write code", int'(wa[0]), 8'h34);
            chk("R5", "clock lane write value", int'(wd[0]), 8'h15);
            chk("R5", "range write code", int'(wa[1]), 8'h44);
            chk(inject ? "R10" : "R5", "range write value", int'(wd[1]), int'({1'b0, f}));
        end
        chk("R3", "lane config at TESTCLR release", int'(cfg_ok), 1);
        chk_ge("R4", "TESTCLR high clocks", t_clr_fall - t_clr_rise, WCLR);
        chk_ge("R4", "TESTCLR release to first access", t_en_first - t_clr_fall, WCLR);
        chk_ge("R8", "ENABLECLK after last access", t_enclk_rise - t_en_last_fall, 1);
        chk_ge("R8", "SHUTDOWNZ after ENABLECLK", t_sd_rise - t_enclk_rise, WEN);
        chk_ge("R8", "RSTZ after SHUTDOWNZ", t_rstz_rise - t_sd_rise, WEN);
        chk("R9", "ready rises with RSTZ", t_ready_rise, t_rstz_rise);
        chk("R9", "busy low when ready", int'(busy), 0);
        chk("R6", "TESTCLK parked", int'(tclk), 1);
        chk("R6", "TESTEN parked", int'(ten), 0);
        if (from_ready) begin
            chk_ge("R2", "RSTZ dropped", t_rstz_fall, 0);
            chk_ge("R2", "SHUTDOWNZ after RSTZ", t_sd_fall - t_rstz_fall, 1);
            chk_ge("R2", "TESTCLR after SHUTDOWNZ", t_clr_rise - t_sd_fall, 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1", "RSTZ", int'(rstz), 0);
        chk("R1", "SHUTDOWNZ", int'(sd), 0);
        chk("R1", "TESTCLR", int'(clr), 0);
        chk("R1", "ENABLECLK", int'(enclk), 0);
        chk("R1", "ready", int'(ready), 0);
        chk("R1", "busy", int'(busy), 0);
        chk("R1", "TESTCLK", int'(tclk), 1);
        chk("R1", "TESTEN", int'(ten), 0);
        chk("R1", "lane buses", int'({tdis, treq, frx}), 0);

        for (int i = 0; i < 6; i++) begin
            bringup(VECS[i][12:9], VECS[i][8:2], int'(VECS[i][1:0]), i > 0, i == 2);
        end

        // R11 standby from ready
        standby = 1'b1; clr_log = 1'b1;
        tick();
        standby = 1'b0; clr_log = 1'b0;
        repeat (4) tick();
        chk("R11", "SHUTDOWNZ after standby", int'(sd), 0);
        chk("R11", "RSTZ after standby", int'(rstz), 0);
        chk("R11", "ENABLECLK after standby", int'(enclk), 0);
        chk("R11", "ready after standby", int'(ready), 0);
        chk("R11", "busy after standby", int'(busy), 0);
        chk_ge("R11", "RSTZ drop after SHUTDOWNZ drop", t_rstz_fall - t_sd_fall, 1);

        // R11 standby while idle has no effect
        standby = 1'b1;
        tick();
        standby = 1'b0;
        repeat (4) tick();
        chk("R11", "idle standby leaves busy low", int'(busy), 0);
        chk("R11", "idle standby leaves control lines", int'({rstz, sd, clr, enclk}), 0);
        chk("R11", "idle standby leaves TESTEN low", int'(ten), 0);

        // R7 empty mask, started from idle
        bringup(4'h0, 7'h11, 0, 1'b0, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule